// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

An asynchronous serial transmitter with a one-byte holding buffer in front of a frame shift register. Software writes a byte into the holding buffer. The byte moves into the shift register at the next bit-rate tick of the baud generator, and not at the moment of the write. From there it is sent on the serial line as a frame: a start bit, eight data bits with the least significant bit first, an optional parity bit, and one stop bit. A byte written while a frame is on the line waits in the buffer. It is sent back to back with the frame ahead of it.

The baud generator takes its count source from the system clock, either undivided or divided by 8 or by 32. A reload counter then divides that source by (n+1), and a fixed oversampling divider divides it by 16. One bit therefore lasts 16·(n+1) count-source periods.

Three status outputs report the transmitter state: a buffer-empty flag, a shift-register-empty flag, and an interrupt request. The interrupt request is raised either when a byte is moved out of the buffer or when transmission completes, depending on a select input. It is cleared by an acknowledge pulse or by a software clear pulse.

Top module: `dbuf_uart_tx`

## Requirements
- R1: The line `txd` idles at 1. A frame is a start bit (0), then data bits D0 to D7 with D0 first, then a parity bit when `par_en`=1, then a stop bit (1). Each bit is held for one bit time.
- R2: The bit time is DIV·16·(`brg_n`+1) clock cycles. DIV is 1 for `clk_sel`=0, 8 for `clk_sel`=1, and 32 for `clk_sel`=2 or 3.
- R3: With `par_odd`=0 the parity bit makes the count of ones over the data and parity even. With `par_odd`=1 it makes that count odd.
- R4: A cycle with `wr_en`=1 drives `buf_empty` to 0 from the next cycle. `buf_empty` returns to 1 in the cycle in which the byte moves into the shift register.
- R5: The move into the shift register, and the start bit with it, happens at a bit-rate tick. This is at most one bit time after the write, never in the same edge as the write. `txd` stays 1 until then.
- R6: `shift_empty` is 0 from the move until the end of the stop bit. It is 1 after the stop bit if no byte is waiting.
- R7: With `irq_sel`=0, `irq` is 1 from the cycle in which `buf_empty` returns to 1.
- R8: With `irq_sel`=1, `irq` is 1 from the cycle in which `shift_empty` returns to 1. It is not raised by the move.
- R9: A pulse on `irq_ack` or on `irq_clr` clears `irq` from the next cycle. A set event in the same cycle takes priority.
- R10: A byte written during a frame goes out directly after the stop bit. Its start bit begins at the very edge where the stop bit ends, and `shift_empty` stays 0.
- R11: While `tx_en`=0 no byte leaves the buffer, and `buf_empty` and `shift_empty` keep their values. A frame already on the line finishes normally.
- R12: After reset: `txd`=1, `buf_empty`=1, `shift_empty`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_n | input | 8 | Baud reload value n |
| clk_sel | input | 2 | Count source: 0 undivided, 1 divide by 8, 2/3 divide by 32 |
| tx_en | input | 1 | Allows transfers out of the buffer |
| par_en | input | 1 | Adds a parity bit to the frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| irq_sel | input | 1 | 0 raises the interrupt on the move, 1 raises it on completion |
| wr_en | input | 1 | Write strobe for the buffer |
| wr_data | input | 8 | Byte to send |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr | input | 1 | Software clear pulse for the interrupt |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | Shift register is idle |
| irq | output | 1 | Interrupt request |

## Verification
A baud-phase fault shows at the ports as a move that lands too late or too early after a write. `buf_empty` rises off schedule, and every mid-bit sample of `txd` then shifts by a fraction of a bit within the same frame. A wrong shift count or parity state shows as a wrong level at one mid-bit sample of that frame. A wrong handover between buffer and shift register shows one bit time after the stop bit at the latest: as an idle gap, a lost queued byte, or a flag that disagrees with the line.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // prescale factor picked by the clock-source select
  function automatic int src_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      default: return 32;
    endcase
  endfunction

  // parity bit over the data byte; odd=1 gives odd total parity
  function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // number of bit slots in one frame
  function automatic logic [CNT_W-1:0] frame_len(input logic pe);
    return pe ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
  endfunction
endpackage

// File: rtl/dbtx_baud.sv
module dbtx_baud #(
  parameter int BRG_W = 8,
  parameter int OVS   = 16,
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRG_W-1:0] brg_n,
  input  logic [1:0]       clk_sel,
  output logic             bit_tick
);
  import dbtx_pkg::*;
  localparam int SUB_W = $clog2(OVS);

  logic [PSC_W-1:0] psc;
  logic [BRG_W-1:0] reload_cnt;
  logic [SUB_W-1:0] sub;
  logic             fi_en;
  logic             brg_ovf;
  logic [PSC_W-1:0] psc_top;

  assign psc_top  = PSC_W'(src_div(clk_sel) - 1);
  assign fi_en    = (psc >= psc_top);
  assign brg_ovf  = fi_en && (reload_cnt == '0);
  assign bit_tick = brg_ovf && (sub == SUB_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc        <= '0;
      reload_cnt <= '0;
      sub        <= '0;
    end else begin
      psc <= fi_en ? '0 : psc + 1'b1;
      if (fi_en)
        reload_cnt <= (reload_cnt == '0) ? brg_n : reload_cnt - 1'b1;
      if (brg_ovf)
        sub <= sub + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick || (src_div(clk_sel) == 1 && brg_n == '0 && OVS == 1)); // R2
endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter
  import dbtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              txd,
  output logic              busy,
  output logic              last_done
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;

  assign last_done = bit_tick && busy && (left == CNT_W'(1));
  assign txd       = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= {1'b1, (par_en ? parity_of(data, par_odd) : 1'b1), data, 1'b0};
      left <= frame_len(par_en);
      busy <= 1'b1;
    end else if (bit_tick && busy) begin
      if (left == CNT_W'(1)) begin
        busy <= 1'b0;
      end else begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd); // R1
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |-> txd); // R1
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !load) |=> $stable(txd)); // R1
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbtx_pkg::*;
#(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRG_W-1:0] brg_n,
  input  logic [1:0]       clk_sel,
  input  logic             tx_en,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             irq_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             irq_ack,
  input  logic             irq_clr,
  output logic             txd,
  output logic             buf_empty,
  output logic             shift_empty,
  output logic             irq
);
  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic              bit_tick;
  logic              busy;
  logic              last_done;
  logic              load;
  logic              irq_set;

  dbtx_baud #(.BRG_W(BRG_W), .OVS(16), .PSC_W(5)) u_baud (
    .clk(clk), .rst_n(rst_n), .brg_n(brg_n), .clk_sel(clk_sel), .bit_tick(bit_tick)
  );

  dbtx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(load), .data(hold_q),
    .par_en(par_en), .par_odd(par_odd), .txd(txd), .busy(busy), .last_done(last_done)
  );

  assign load        = bit_tick && hold_full && tx_en && (!busy || last_done);
  assign irq_set     = irq_sel ? (last_done && !load) : load;
  assign buf_empty   = !hold_full;
  assign shift_empty = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (irq_set)
        irq <= 1'b1;
      else if (irq_ack || irq_clr)
        irq <= 1'b0;
    end
  end

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty); // R4
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(bit_tick)); // R5
  AST_IRQ_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !irq_sel) |=> irq); // R7
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(shift_empty) && $past(irq_sel)) |-> irq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ack || irq_clr) && !irq_set) |=> !irq); // R9
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && shift_empty) |=> shift_empty); // R11
endmodule

// File: tb/dbuf_uart_tx_bench.sv
`timescale 1ns/1ps
module dbuf_uart_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] brg_n = 8'd0;
  logic [1:0] clk_sel = 2'd0;
  logic       tx_en = 1'b1, par_en = 1'b1, par_odd = 1'b0, irq_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_ack = 1'b0, irq_clr = 1'b0;
  logic       txd, buf_empty, shift_empty, irq;

  int n_run = 0;
  int n_fail = 0;
  int cur_b = 16;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dbuf_uart_tx u_dbuf_uart_tx (
    .clk(clk), .rst_n(rst_n), .brg_n(brg_n), .clk_sel(clk_sel), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .irq_sel(irq_sel), .wr_en(wr_en),
    .wr_data(wr_data), .irq_ack(irq_ack), .irq_clr(irq_clr), .txd(txd),
    .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
  );

  function automatic int bit_time(input int n, input int sel);
    int div;
    div = (sel == 0) ? 1 : (sel == 1) ? 8 : 32;
    return div * 16 * (n + 1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic pe,
                                   input logic odd, input int i);
    int ones;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += d[k];
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == 9 && pe) return ((ones % 2) == 1) ? !odd : odd;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int n, input int sel, input logic pe, input logic odd,
                         input logic isel);
    @(negedge clk);
    brg_n = 8'(n); clk_sel = 2'(sel); par_en = pe; par_odd = odd; irq_sel = isel;
    cur_b = bit_time(n, sel);
    repeat (1100) @(negedge clk);
  endtask

  // drive a write at the current negedge, release at the next
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_move();
    int cnt;
    bit line_ok;
    cnt = 0; line_ok = 1'b1;
    while (!buf_empty && cnt < 4 * cur_b) begin
      if (txd !== 1'b1 && shift_empty) line_ok = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(buf_empty && cnt <= cur_b, "R5 move within one bit time", cnt, cur_b);
    chk(line_ok, "R5 line idle before move", 0, 1);
  endtask

  task automatic check_frame(input logic [7:0] d, input int skip);
    int nb;
    nb = par_en ? 11 : 10;
    repeat (cur_b / 2 - skip) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      chk(txd === exp_bit(d, par_en, par_odd, i),
          (i == 9 && par_en) ? "R3 parity bit" : "R1 R2 frame bit",
          int'(txd), int'(exp_bit(d, par_en, par_odd, i)));
      if (i == 4) chk(shift_empty === 1'b0, "R6 busy mid frame", int'(shift_empty), 0);
      if (i < nb - 1) repeat (cur_b) @(negedge clk);
    end
    repeat (cur_b / 2) @(negedge clk);
  endtask

  task automatic one_frame(input logic [7:0] d);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    wr(d);
    chk(buf_empty === 1'b0, "R4 write clears buf_empty", int'(buf_empty), 0);
    wait_move();
    chk(txd === 1'b0, "R1 start bit at move", int'(txd), 0);
    chk(irq === !irq_sel, irq_sel ? "R8 no irq on move" : "R7 irq on move",
        int'(irq), int'(!irq_sel));
    check_frame(d, 0);
    chk(shift_empty === 1'b1, "R6 empty after stop", int'(shift_empty), 1);
    chk(txd === 1'b1, "R1 idle after frame", int'(txd), 1);
    chk(irq === 1'b1, irq_sel ? "R8 irq on completion" : "R7 irq held", int'(irq), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d2;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && buf_empty === 1'b1 && shift_empty === 1'b1 && irq === 1'b0,
        "R12 reset state", {txd, buf_empty, shift_empty, irq}, 4'b1110);
    rst_n = 1'b1;
    cur_b = bit_time(0, 0);
    repeat (40) @(negedge clk);

    // directed corner patterns, even and odd parity, no parity
    set_cfg(0, 0, 1'b1, 1'b0, 1'b0); one_frame(8'h00); one_frame(8'hFF);
    set_cfg(1, 0, 1'b1, 1'b1, 1'b1); one_frame(8'hA5);
    set_cfg(2, 0, 1'b0, 1'b0, 1'b0); one_frame(8'h81);

    // R9: acknowledge and software clear
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq === 1'b0, "R9 ack clears irq", int'(irq), 0);
    set_cfg(0, 0, 1'b0, 1'b0, 1'b0); one_frame(8'h3C);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(irq === 1'b0, "R9 clear pulse clears irq", int'(irq), 0);

    // R2: prescaled count sources
    set_cfg(1, 1, 1'b1, 1'b0, 1'b1); one_frame(8'h01);
    set_cfg(0, 2, 1'b0, 1'b1, 1'b0); one_frame(8'h6B);
    set_cfg(0, 3, 1'b1, 1'b1, 1'b0); one_frame(8'hE7);

    // R10: back-to-back
    set_cfg(1, 0, 1'b1, 1'b0, 1'b0);
    wr(8'h5A);
    wait_move();
    wr(8'hC3);
    check_frame(8'h5A, 1);
    chk(txd === 1'b0 && shift_empty === 1'b0 && buf_empty === 1'b1,
        "R10 next start follows stop", {txd, shift_empty, buf_empty}, 3'b001);
    check_frame(8'hC3, 0);
    chk(shift_empty === 1'b1, "R10 empty after second frame", int'(shift_empty), 1);

    // R11: disable holds buffer, lets running frame finish
    wr(8'h96);
    wait_move();
    tx_en = 1'b0;
    wr(8'h11);
    check_frame(8'h96, 1);
    chk(shift_empty === 1'b1 && buf_empty === 1'b0, "R11 running frame finished, byte held",
        {shift_empty, buf_empty}, 2'b10);
    repeat (3 * cur_b) @(negedge clk);
    chk(txd === 1'b1 && buf_empty === 1'b0 && shift_empty === 1'b1,
        "R11 no transfer while disabled", {txd, buf_empty, shift_empty}, 3'b101);
    tx_en = 1'b1;
    wait_move();
    check_frame(8'h11, 0);

    // random mix with a fixed seed
    void'($urandom(32'h1234_5678));
    for (int it = 0; it < 10; it++) begin
      set_cfg(int'($urandom_range(0, 3)), 0, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      d2 = 8'($urandom);
      one_frame(d2);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule